// File: doc/BRIEF.md
# Four-Bank Asynchronous DRAM Controller with CAS-Before-RAS Refresh

The controller turns single-word CPU requests into strobe sequences for an array of up to four asynchronous DRAM banks. A request carries a 26-bit byte address, a write flag, four byte enables and write data. Once the request is accepted, the controller picks a bank by comparing the upper address bits against each bank's base register. It splits the word address into a row and a column according to that bank's device size. It then drives the row, then the column, on a 12-bit multiplexed address bus. One cycle after the column strobe ends, it returns a single-cycle acknowledge, with read data captured from the memory data bus.

A countdown timer raises refresh requests. When the controller is idle, a pending refresh takes precedence over a waiting CPU request. A refresh lowers all column strobes first, then all row strobes, then releases the column strobes, and finally releases the row strobes. Every phase length comes from small fields in a byte-wide register file. Software reaches that register file by writing an index and then reading or writing data.

The state machine has seven states. ST_IDLE moves to ST_RCAS when a refresh is pending, moves to ST_ROW when a request decodes to an enabled bank, and otherwise stays in ST_IDLE (acknowledging an unmapped request). ST_ROW moves to ST_COL, and ST_COL moves to ST_PRE. ST_RCAS moves to ST_RRAS, ST_RRAS moves to ST_RHOLD, and ST_RHOLD moves to ST_PRE. ST_PRE returns to ST_IDLE. Each timed state leaves when its down-counter reaches zero.

Top module: `dram_ctrl`

## Requirements
- R1: An accepted request lowers the RAS# line of exactly one bank. Bank b matches when it is enabled and addr[25:18] equals its base byte, ignoring the low 2+2*type bits of the base. When several banks match, the lowest-numbered bank wins.
- R2: The bank type t sets c = 9+t column bits. The column is word-address bits [c-1:0] and the row is word-address bits [2c-1:c], where the word address is addr[25:2]. Type codes are 0 = 256K, 1 = 1M, 2 = 4M and 3 = 16M cells. The row is on MA while RAS# is low and CAS# is high; the column is on MA while CAS# is low.
- R3: During the column phase, cas_n[i] is low exactly when be[i] is set. On a write, we_n is low, md_oe is high and md_out carries the write data. On a read, we_n stays high.
- R4: A disabled bank never receives RAS# for an access. A request that matches no enabled bank is acknowledged one cycle after it is sampled, with no strobe activity and rdata = 0.
- R5: When the hole-exclude bit (register 0 bit 4) is set, addresses 0xA0000 through 0xFFFFF are treated as unmapped. When the bit is clear, those addresses decode normally.
- R6: RAS# is held low for (rcd+1)+(cas+1) cycles, and CAS# for cas+1 cycles. rcd and cas are the read fields or the write fields, depending on the request. The acknowledge is a one-cycle pulse in the first cycle after CAS# rises, and on a read rdata holds the md_in value from the last CAS# cycle.
- R7: After RAS# rises, all RAS# lines stay high for max(rp,cp)+1 precharge cycles plus one idle cycle. The next fall is therefore at least max(rp,cp)+2 cycles after the rise.
- R8: A refresh drives CAS#-low/RAS#-high on all lines for ref_cr+1 cycles, then all lines low for ref_rc+1 cycles, then RAS#-low/CAS#-high for ref_tail+1 cycles.
- R9: Refreshes start every period+1 cycles when the bus is otherwise idle. Writing either period byte restarts the countdown.
- R10: If a refresh is pending while the controller is idle, refresh starts first, even if a CPU request is present in the same cycle. The CPU request is served after the refresh completes.
- R11: A write with cfg_sel=0 sets the index; cfg_sel=1 writes to or reads from the indexed register. Indices 10 to 15 read as zero and ignore writes.
- R12: After reset, all strobes are high, ack is low, every register is zero except the period (0xFFFF), and the register layout is as follows. Index 0 holds the enables in [3:0] and the hole bit in [4]. Index 1 holds the types, with bank b in [2b+1:2b]. Index 2 holds rcd_rd [1:0], rcd_wr [3:2], rp [5:4] and cp [6]. Index 3 holds cas_rd [1:0], cas_wr [2], ref_cr [3], ref_rc [5:4] and ref_tail [7:6]. Indices 4 and 5 hold the period low and high bytes. Indices 6 to 9 hold the bases of banks 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | CPU request, held until ack |
| req_we | input | 1 | Request is a write |
| req_addr | input | 26 | Byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with ack |
| cfg_sel | input | 1 | 0 = index write, 1 = data access |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Indexed register contents |
| ma | output | 12 | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes, one per bank |
| cas_n | output | 4 | Column strobes, one per byte lane |
| we_n | output | 1 | DRAM write enable |
| md_out | output | 32 | Write data to the array |
| md_oe | output | 1 | Data bus drive enable |
| md_in | input | 32 | Read data from the array |

## Verification
A wrong bank decode or type split shows up in the first RAS# cycle of an access, as the wrong line low or the wrong row on MA. A wrong column appears one phase later. A miscounted phase counter changes the RAS#-low and CAS#-low lengths of that same access. A lost or late refresh-pending flag shifts the next refresh start away from period+1, or lets a CPU RAS# fall in the cycle where refresh was due. A stuck state leaves ack missing within a few tens of cycles.

// File: rtl/dram_pkg.sv
package dram_pkg;
    localparam int NBANK   = 4;
    localparam int ADDR_W  = 26;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int MA_W    = 12;
    localparam int BASE_W  = 8;
    localparam int TMR_W   = 16;
    localparam int IDX_W   = 4;
    localparam int MIN_COL = 9;
    localparam int HOLE_LO = 'hA0000;
    localparam int HOLE_HI = 'hFFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_RCAS,
        ST_RRAS,
        ST_RHOLD
    } dstate_t;

    typedef struct packed {
        logic [1:0] rcd_rd;
        logic [1:0] rcd_wr;
        logic [1:0] rp;
        logic       cp;
        logic [1:0] cas_rd;
        logic       cas_wr;
        logic       ref_cr;
        logic [1:0] ref_rc;
        logic [1:0] ref_tail;
    } tim_t;

    function automatic logic [1:0] max2(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dram_cfg_regs.sv
module dram_cfg_regs
    import dram_pkg::*;
#(
    parameter int NB  = NBANK,
    parameter int IW  = IDX_W,
    parameter int BW  = BASE_W,
    parameter int TW  = TMR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_sel,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    output logic [NB-1:0]        bank_en,
    output logic                 hole_excl,
    output logic [NB-1:0][1:0]   types,
    output logic [NB-1:0][BW-1:0] bases,
    output tim_t                 tim,
    output logic [TW-1:0]        period,
    output logic                 period_wr
);
    localparam int IDX_BASE = 6;
    localparam int NREG     = IDX_BASE + NB;

    logic [IW-1:0] idx;
    logic [7:0]    regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= ((i == 4) || (i == 5)) ? 8'hFF : 8'h00;
            end
        end else if (cfg_wr) begin
            if (!cfg_sel) begin
                idx <= cfg_wdata[IW-1:0];
            end else begin
                for (int i = 0; i < NREG; i++) begin
                    if (idx == IW'(i)) regs[i] <= cfg_wdata;
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IW'(i)) cfg_rdata = regs[i];
        end
    end

    assign period_wr = cfg_wr && cfg_sel && ((idx == IW'(4)) || (idx == IW'(5)));
    assign period    = TW'({regs[5], regs[4]});

    assign bank_en   = regs[0][NB-1:0];
    assign hole_excl = regs[0][4];

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank_fields
            assign types[b] = regs[1][2*b +: 2];
            assign bases[b] = regs[IDX_BASE + b][BW-1:0];
        end
    endgenerate

    assign tim.rcd_rd   = regs[2][1:0];
    assign tim.rcd_wr   = regs[2][3:2];
    assign tim.rp       = regs[2][5:4];
    assign tim.cp       = regs[2][6];
    assign tim.cas_rd   = regs[3][1:0];
    assign tim.cas_wr   = regs[3][2];
    assign tim.ref_cr   = regs[3][3];
    assign tim.ref_rc   = regs[3][5:4];
    assign tim.ref_tail = regs[3][7:6];

    logic unused_bits;
    assign unused_bits = ^{regs[0][7:5], regs[2][7]};
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer
    import dram_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] period,
    input  logic          restart,
    input  logic          taken,
    output logic          pend
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '1;
            pend <= 1'b0;
        end else begin
            if (taken) pend <= 1'b0;
            if (restart) begin
                cnt <= period;
            end else if (cnt == '0) begin
                cnt  <= period;
                pend <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_PEND_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(cnt) == '0)); // R9
endmodule

// File: rtl/dram_bank_map.sv
module dram_bank_map
    import dram_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int AW = ADDR_W,
    parameter int BW = BASE_W,
    parameter int MW = MA_W
) (
    input  logic [AW-1:0]          addr,
    input  logic [NB-1:0]          bank_en,
    input  logic                   hole_excl,
    input  logic [NB-1:0][1:0]     types,
    input  logic [NB-1:0][BW-1:0]  bases,
    output logic                   hit,
    output logic [NB-1:0]          sel,
    output logic [MW-1:0]          row,
    output logic [MW-1:0]          col
);
    localparam int WA_W = AW - 2;

    logic [NB-1:0] match;
    logic [NB-1:0] first;
    logic [1:0]    typ;
    logic          in_hole;
    logic [WA_W-1:0] wa;
    logic [WA_W-1:0] cmask;
    logic [3:0]    cbits;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_match
            logic [BW-1:0] mask;
            assign mask     = {BW{1'b1}} << (4'd2 + {1'b0, types[b], 1'b0});
            assign match[b] = bank_en[b] &&
                              (((addr[AW-1 -: BW] ^ bases[b]) & mask) == '0);
        end
    endgenerate

    always_comb begin
        first = '0;
        typ   = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (match[b]) begin
                first    = '0;
                first[b] = 1'b1;
                typ      = types[b];
            end
        end
    end

    assign in_hole = hole_excl && (addr >= AW'(HOLE_LO)) && (addr <= AW'(HOLE_HI));
    assign sel     = in_hole ? '0 : first;
    assign hit     = |sel;

    assign wa    = addr[AW-1:2];
    assign cbits = 4'(MIN_COL) + {2'b00, typ};
    assign cmask = ~({WA_W{1'b1}} << cbits);
    assign col   = MW'(wa & cmask);
    assign row   = MW'((wa >> cbits) & cmask);

    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int MW = MA_W,
    parameter int TW = TMR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  logic           req_we,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW/8-1:0] req_be,
    input  logic [DW-1:0]  req_wdata,
    output logic           ack,
    output logic [DW-1:0]  rdata,
    input  logic           cfg_sel,
    input  logic           cfg_wr,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic [MW-1:0]  ma,
    output logic [NB-1:0]  ras_n,
    output logic [DW/8-1:0] cas_n,
    output logic           we_n,
    output logic [DW-1:0]  md_out,
    output logic           md_oe,
    input  logic [DW-1:0]  md_in
);
    localparam int LANES = DW / 8;

    logic [NB-1:0]          bank_en;
    logic                   hole_excl;
    logic [NB-1:0][1:0]     types;
    logic [NB-1:0][BASE_W-1:0] bases;
    tim_t                   tim;
    logic [TW-1:0]          period;
    logic                   period_wr;
    logic                   ref_pend;
    logic                   ref_taken;
    logic                   map_hit;
    logic [NB-1:0]          map_sel;
    logic [MW-1:0]          map_row, map_col;

    dram_cfg_regs #(.NB(NB), .IW(IDX_W), .BW(BASE_W), .TW(TW)) u_regs (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bank_en(bank_en),
        .hole_excl(hole_excl), .types(types), .bases(bases), .tim(tim),
        .period(period), .period_wr(period_wr)
    );

    dram_ref_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .period(period), .restart(period_wr),
        .taken(ref_taken), .pend(ref_pend)
    );

    dram_bank_map #(.NB(NB), .AW(AW), .BW(BASE_W), .MW(MW)) u_map (
        .addr(req_addr), .bank_en(bank_en), .hole_excl(hole_excl),
        .types(types), .bases(bases), .hit(map_hit), .sel(map_sel),
        .row(map_row), .col(map_col)
    );

    dstate_t    state, state_nxt;
    logic [1:0] cnt, cnt_nxt;
    logic [1:0] pre_len;
    logic       accept;

    logic [NB-1:0]    sel_q;
    logic [MW-1:0]    row_q, col_q;
    logic             we_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    wdata_q;
    logic             ack_q;
    logic [DW-1:0]    rdata_q;

    assign pre_len   = max2(tim.rp, {1'b0, tim.cp});
    assign ref_taken = (state == ST_IDLE) && ref_pend;
    assign accept    = (state == ST_IDLE) && !ref_pend && req && !ack_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = (cnt == '0) ? '0 : cnt - 1'b1;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend) begin
                    state_nxt = ST_RCAS;
                    cnt_nxt   = {1'b0, tim.ref_cr};
                end else if (accept && map_hit) begin
                    state_nxt = ST_ROW;
                    cnt_nxt   = req_we ? tim.rcd_wr : tim.rcd_rd;
                end
            end
            ST_ROW: if (cnt == '0) begin
                state_nxt = ST_COL;
                cnt_nxt   = we_q ? {1'b0, tim.cas_wr} : tim.cas_rd;
            end
            ST_COL: if (cnt == '0) begin
                state_nxt = ST_PRE;
                cnt_nxt   = pre_len;
            end
            ST_PRE: if (cnt == '0) begin
                state_nxt = ST_IDLE;
            end
            ST_RCAS: if (cnt == '0) begin
                state_nxt = ST_RRAS;
                cnt_nxt   = tim.ref_rc;
            end
            ST_RRAS: if (cnt == '0) begin
                state_nxt = ST_RHOLD;
                cnt_nxt   = tim.ref_tail;
            end
            ST_RHOLD: if (cnt == '0) begin
                state_nxt = ST_PRE;
                cnt_nxt   = pre_len;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // request capture and completion
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            row_q   <= '0;
            col_q   <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (accept) begin
                if (map_hit) begin
                    sel_q   <= map_sel;
                    row_q   <= map_row;
                    col_q   <= map_col;
                    we_q    <= req_we;
                    be_q    <= req_be;
                    wdata_q <= req_wdata;
                end else begin
                    ack_q   <= 1'b1;
                    rdata_q <= '0;
                end
            end
            if ((state == ST_COL) && (cnt == '0)) begin
                ack_q <= 1'b1;
                if (!we_q) rdata_q <= md_in;
            end
        end
    end

    // outputs
    always_comb begin
        ras_n  = '1;
        cas_n  = '1;
        we_n   = 1'b1;
        ma     = '0;
        md_oe  = 1'b0;
        unique case (state)
            ST_ROW: begin
                ras_n = ~sel_q;
                ma    = row_q;
            end
            ST_COL: begin
                ras_n = ~sel_q;
                cas_n = ~be_q;
                ma    = col_q;
                we_n  = ~we_q;
                md_oe = we_q;
            end
            ST_RCAS: cas_n = '0;
            ST_RRAS: begin
                ras_n = '0;
                cas_n = '0;
            end
            ST_RHOLD: ras_n = '0;
            default: ;
        endcase
    end

    assign md_out = wdata_q;
    assign ack    = ack_q;
    assign rdata  = rdata_q;

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        (ras_n != '0) |-> $onehot0(~ras_n)); // R1
    AST_NO_DISABLED_RAS: assert property (@(posedge clk) disable iff (rst)
        (ras_n != '0) |-> ((~ras_n & ~bank_en) == '0)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R6
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        (($past(ras_n) != '1) && (ras_n == '1)) |=> (ras_n == '1)); // R7
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n[0]) && (ras_n == '0)) |-> ($past(cas_n) == '0)); // R8
    AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && ref_pend) |=> ((cas_n == '0) && (ras_n == '1))); // R10
endmodule

// File: tb/sim_dram_ctrl.sv
module sim_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PER = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [25:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic        cfg_sel = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [11:0] ma;
    logic [3:0]  ras_n, cas_n;
    logic        we_n, md_oe;
    logic [31:0] md_out, md_in;

    assign md_in = 32'hA5C3_0000 | {20'h0, ma};

    dram_ctrl u0 (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .md_out(md_out), .md_oe(md_oe), .md_in(md_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = {4'h0, idx};
        @(negedge clk); cfg_sel = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = {4'h0, idx};
        @(negedge clk); cfg_wr = 1'b0; cfg_sel = 1'b1;
        d = cfg_rdata;
    endtask

    // expected row/column from R2
    function automatic logic [23:0] split(input logic [25:0] a, input int t, input bit want_row);
        int c = 9 + t;
        logic [23:0] wa = a[25:2];
        logic [23:0] m = (24'd1 << c) - 24'd1;
        return want_row ? ((wa >> c) & m) : (wa & m);
    endfunction

    // access observation results
    logic [3:0]  a_banks, a_cas_pat;
    int          a_ras_cnt, a_cas_cnt, a_gap;
    logic [11:0] a_ma_row, a_ma_col;
    logic        a_we_low, a_oe, a_done;
    logic [31:0] a_mdout, a_rdata;

    task automatic do_access(input bit w, input logic [25:0] a, input logic [3:0] be, input logic [31:0] d);
        bit seen = 0;
        req = 1'b1; req_we = w; req_addr = a; req_be = be; req_wdata = d;
        a_banks = '0; a_ras_cnt = 0; a_cas_cnt = 0; a_gap = 0; a_done = 1'b0;
        a_cas_pat = '1; a_ma_row = '0; a_ma_col = '0; a_we_low = 0; a_oe = 0;
        a_mdout = '0; a_rdata = '0;
        for (int i = 0; i < 100 && !a_done; i++) begin
            @(negedge clk);
            if (ras_n != 4'hF) begin
                if (!seen) a_ma_row = ma;
                seen = 1;
                a_banks |= ~ras_n;
                a_ras_cnt++;
            end else if (!seen) begin
                a_gap++;
            end
            if (cas_n != 4'hF) begin
                if (a_cas_cnt == 0) begin
                    a_cas_pat = cas_n; a_ma_col = ma; a_we_low = !we_n;
                    a_oe = md_oe; a_mdout = md_out;
                end
                a_cas_cnt++;
            end
            if (ack) begin a_done = 1'b1; a_rdata = rdata; end
        end
        req = 1'b0;
        chk(a_done, "R6 ack received", {31'h0, a_done}, 32'h1);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        @(negedge clk);
        chk(ras_n == 4'hF && cas_n == 4'hF && we_n, "R12 strobes idle", {ras_n, cas_n, 23'h0, we_n}, 32'hFF00_0001);
        chk(!ack, "R12 no ack", {31'h0, ack}, 32'h0);
        cfg_read(4'd5, v);
        chk(v == 8'hFF, "R12 period high byte", {24'h0, v}, 32'hFF);
        cfg_read(4'd0, v);
        chk(v == 8'h00, "R12 control zero", {24'h0, v}, 32'h0);
    endtask

    task automatic t_config;
        logic [7:0] v;
        cfg_write(4'd0, 8'h0B);
        cfg_write(4'd1, 8'hB1);
        cfg_write(4'd2, 8'h29);
        cfg_write(4'd3, 8'h6E);
        cfg_write(4'd6, 8'h00);
        cfg_write(4'd7, 8'h10);
        cfg_write(4'd8, 8'h00);
        cfg_write(4'd9, 8'h40);
        cfg_write(4'd12, 8'h77);
        cfg_read(4'd2, v);
        chk(v == 8'h29, "R11 timing readback", {24'h0, v}, 32'h29);
        cfg_read(4'd7, v);
        chk(v == 8'h10, "R11 base readback", {24'h0, v}, 32'h10);
        cfg_read(4'd12, v);
        chk(v == 8'h00, "R11 unused index", {24'h0, v}, 32'h0);
    endtask

    task automatic t_read_bank0;
        logic [25:0] a = 26'h012_3454;
        do_access(1'b0, a, 4'b1111, 32'h0);
        chk(a_banks == 4'b0001, "R1 bank0 selected", {28'h0, a_banks}, 32'h1);
        chk(a_ma_row == split(a, 1, 1)[11:0], "R2 row type1", {20'h0, a_ma_row}, {20'h0, split(a, 1, 1)[11:0]});
        chk(a_ma_col == split(a, 1, 0)[11:0], "R2 col type1", {20'h0, a_ma_col}, {20'h0, split(a, 1, 0)[11:0]});
        chk(a_ras_cnt == 5 && a_cas_cnt == 3, "R6 read phase lengths", a_ras_cnt * 16 + a_cas_cnt, 32'h53);
        chk(!a_we_low && a_cas_pat == 4'b0000, "R3 read strobes", {27'h0, a_we_low, a_cas_pat}, 32'h0);
        chk(a_rdata == (32'hA5C3_0000 | {20'h0, a_ma_col}), "R6 read data", a_rdata, 32'hA5C3_0000 | {20'h0, a_ma_col});
    endtask

    task automatic t_write_then_read;
        logic [25:0] a = 26'h040_0010;
        do_access(1'b1, a, 4'b0101, 32'hDEAD_BEEF);
        chk(a_banks == 4'b0010, "R1 bank1 selected", {28'h0, a_banks}, 32'h2);
        chk(a_ma_row == split(a, 0, 1)[11:0] && a_ma_col == split(a, 0, 0)[11:0], "R2 type0 split",
            {8'h0, a_ma_row, a_ma_col}, {8'h0, split(a, 0, 1)[11:0], split(a, 0, 0)[11:0]});
        chk(a_cas_pat == 4'b1010, "R3 byte lanes", {28'h0, a_cas_pat}, 32'hA);
        chk(a_we_low && a_oe && a_mdout == 32'hDEAD_BEEF, "R3 write data", a_mdout, 32'hDEAD_BEEF);
        chk(a_ras_cnt == 5 && a_cas_cnt == 2, "R6 write phase lengths", a_ras_cnt * 16 + a_cas_cnt, 32'h52);
        // back-to-back: ack cycle + max(rp,cp)+1 more high cycles
        do_access(1'b0, 26'h000_0100, 4'b1111, 32'h0);
        chk(a_gap + 1 == 4, "R7 precharge gap", a_gap + 1, 32'd4);
    endtask

    task automatic t_bank3_and_priority;
        logic [25:0] a = 26'h123_4568;
        do_access(1'b0, a, 4'b1111, 32'h0);
        chk(a_banks == 4'b1000, "R1 bank3 selected", {28'h0, a_banks}, 32'h8);
        chk(a_ma_row == split(a, 2, 1)[11:0] && a_ma_col == split(a, 2, 0)[11:0], "R2 type2 split",
            {8'h0, a_ma_row, a_ma_col}, {8'h0, split(a, 2, 1)[11:0], split(a, 2, 0)[11:0]});
        cfg_write(4'd0, 8'h0F);
        do_access(1'b0, 26'h000_0100, 4'b1111, 32'h0);
        chk(a_banks == 4'b0001, "R1 lowest bank wins", {28'h0, a_banks}, 32'h1);
        a = 26'h200_0010;
        do_access(1'b0, a, 4'b1111, 32'h0);
        chk(a_banks == 4'b0100 && a_ma_row == split(a, 3, 1)[11:0] && a_ma_col == split(a, 3, 0)[11:0],
            "R2 bank2 type3", {4'h0, a_banks, a_ma_row, a_ma_col}, {8'h04, split(a, 3, 1)[11:0], split(a, 3, 0)[11:0]});
    endtask

    task automatic t_disabled;
        cfg_write(4'd0, 8'h0A);
        do_access(1'b0, 26'h000_0100, 4'b1111, 32'h0);
        chk(a_banks == 4'b0000 && a_cas_cnt == 0, "R4 disabled bank no strobes", {24'h0, a_banks, a_cas_cnt[3:0]}, 32'h0);
        chk(a_rdata == 32'h0, "R4 unmapped rdata", a_rdata, 32'h0);
        cfg_write(4'd0, 8'h0B);
    endtask

    task automatic t_hole;
        cfg_write(4'd0, 8'h1B);
        do_access(1'b0, 26'h00A_0004, 4'b1111, 32'h0);
        chk(a_banks == 4'b0000, "R5 hole excluded", {28'h0, a_banks}, 32'h0);
        do_access(1'b0, 26'h00F_FFFC, 4'b1111, 32'h0);
        chk(a_banks == 4'b0000, "R5 hole top excluded", {28'h0, a_banks}, 32'h0);
        do_access(1'b0, 26'h009_FFFC, 4'b1111, 32'h0);
        chk(a_banks == 4'b0001, "R5 below hole", {28'h0, a_banks}, 32'h1);
        do_access(1'b0, 26'h010_0000, 4'b1111, 32'h0);
        chk(a_banks == 4'b0001, "R5 above hole", {28'h0, a_banks}, 32'h1);
        cfg_write(4'd0, 8'h0B);
        do_access(1'b0, 26'h00A_0004, 4'b1111, 32'h0);
        chk(a_banks == 4'b0001, "R5 hole decoded when clear", {28'h0, a_banks}, 32'h1);
    endtask

    task automatic find_ref_start(output bit found);
        found = 0;
        for (int i = 0; i < 500 && !found; i++) begin
            @(negedge clk);
            if (!(cas_n == 4'h0 && ras_n == 4'hF)) begin
                for (int j = 0; j < 500 && !found; j++) begin
                    @(negedge clk);
                    if (cas_n == 4'h0 && ras_n == 4'hF) found = 1;
                end
            end
        end
    endtask

    task automatic t_refresh;
        bit found;
        int s1, s2, na, nb, nc;
        cfg_write(4'd4, 8'(PER));
        cfg_write(4'd5, 8'h00);
        find_ref_start(found);
        chk(found, "R9 refresh seen", {31'h0, found}, 32'h1);
        s1 = cyc; na = 1; nb = 0; nc = 0;
        @(negedge clk);
        while (cas_n == 4'h0 && ras_n == 4'hF && na < 20) begin na++; @(negedge clk); end
        while (cas_n == 4'h0 && ras_n == 4'h0 && nb < 20) begin nb++; @(negedge clk); end
        while (cas_n == 4'hF && ras_n == 4'h0 && nc < 20) begin nc++; @(negedge clk); end
        chk(na == 2, "R8 CAS-first phase", na, 32'd2);
        chk(nb == 3, "R8 both-low phase", nb, 32'd3);
        chk(nc == 2, "R8 RAS tail phase", nc, 32'd2);
        find_ref_start(found);
        s2 = cyc;
        chk(found && (s2 - s1) == PER + 1, "R9 refresh interval", s2 - s1, PER + 1);
    endtask

    task automatic t_collision;
        bit done = 0, bank_seen = 0;
        find_ref_start(found_dummy);
        repeat (PER) @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 26'h000_0200; req_be = 4'hF;
        @(negedge clk);
        chk(cas_n == 4'h0 && ras_n == 4'hF, "R10 refresh wins collision", {24'h0, ras_n, cas_n}, 32'hF0);
        for (int i = 0; i < 60 && !done; i++) begin
            @(negedge clk);
            if (ras_n == 4'b1110) bank_seen = 1;
            if (ack) done = 1;
        end
        req = 1'b0;
        chk(done && bank_seen, "R10 CPU served after refresh", {30'h0, done, bank_seen}, 32'h3);
    endtask
    bit found_dummy;

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_config();
        t_read_bank0();
        t_write_then_read();
        t_bank3_and_priority();
        t_disabled();
        t_hole();
        t_refresh();
        t_collision();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule